// File: doc/BRIEF.md
# SDRAM Mode-Register Programming Controller

This block sits between a CPU-side memory bus and the command pins of the SDRAM devices in two memory areas. Software programs an area's SDRAM mode register with a dummy write into a 4 KB address window set aside for that area. The value to program is carried in the address offset inside the window. Whatever is on the data bus is ignored.

The offset is shifted right to match how the SDRAM address pins are wired for the configured bus width. The block then issues a precharge-all command, waits the row-precharge time, issues the mode-register-set command and waits the mode-register delay. After that it completes the CPU write. Each area has a flag that records a finished programming sequence. Normal access requests to an area are held off until that area's flag is set.

Top module: `sdram_mrs_ctrl`

## Requirements
- R1: A write whose address bits [31:12] equal 0xFFFFD selects area 2, which uses `sd_cs_n[0]`. A write whose address bits [31:12] equal 0xFFFFE selects area 3, which uses `sd_cs_n[1]`. Commands are driven only on the selected area's chip select, active low.
- R2: Only window offsets (address bits [11:0]) from 0x000 to 0xFFC count as a hit. A write at offset 0xFFD to 0xFFF, or a write outside both windows, drives no SDRAM command and never asserts `bus_ready`.
- R3: When `bus_width32` is 1, the mode-register-set command drives `sd_addr` with the window offset shifted right by two. A write to 0xFFFFD8C0 drives 0x230.
- R4: When `bus_width32` is 0, the mode-register-set command drives `sd_addr` with the offset shifted right by one. A write to 0xFFFFE8C2 drives 0x461.
- R5: `bus_wdata` has no effect on the programmed value.
- R6: A write hit produces a precharge-all command in the cycle after it is accepted. Precharge-all is cs/ras/we low, cas high and `sd_addr[10]` high. Then follow T_RP cycles with every command pin high. Then comes a one-cycle mode-register-set command, with cs/ras/cas/we all low.
- R7: After the mode-register-set command, T_MRD idle cycles pass, then `bus_ready` is high for exactly one cycle.
- R8: `acc_grant[i]` is `acc_req[i]` gated by area i's programmed flag. The flag is still clear while that area's sequence runs, is set once the sequence completes, and the two areas' flags are independent.
- R9: A read that hits a window asserts `bus_ready` in the next cycle with `bus_rdata` zero. It issues no SDRAM command and sets no flag.
- R10: Reset deasserts (drives high) every SDRAM command pin, clears both flags and holds `bus_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Bus address, held during the request |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_width32 | input | 1 | 1 = 32-bit bus wiring, 0 = 16-bit |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, always zero |
| acc_req | input | 2 | Normal access request per area (bit 0 area 2, bit 1 area 3) |
| acc_grant | output | 2 | Access grant per area |
| sd_cs_n | output | 2 | SDRAM chip selects (bit 0 area 2, bit 1 area 3) |
| sd_ras_n | output | 1 | SDRAM RAS, active low |
| sd_cas_n | output | 1 | SDRAM CAS, active low |
| sd_we_n | output | 1 | SDRAM WE, active low |
| sd_addr | output | SD_AW | SDRAM address pins |

## Verification
Each wrong internal state of the sequencer shows at the pins:

- A wrongly latched area shows up in the first command cycle as a chip select on the wrong device.
- A latched shift or offset error shows up on `sd_addr` in the mode-register-set cycle, T_RP+1 cycles after the precharge-all.
- An off-by-one in either wait counter moves the mode-register-set command or the `bus_ready` pulse by one cycle.
- A flag set too early or on the wrong area shows up on `acc_grant` in the cycle the bench requests access.

The bench sweeps every word offset for both areas and both bus widths. It checks the exact cycle of every command, so each of these errors shows up within a single transaction.

// File: rtl/sdram_mrs_ctrl.sv
module sdram_mrs_ctrl #(
  parameter int SD_AW = 12,
  parameter int T_RP  = 2,
  parameter int T_MRD = 2,
  parameter logic [19:0] PAGE_A2 = 20'hFFFFD,
  parameter logic [19:0] PAGE_A3 = 20'hFFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [31:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_width32,
  output logic             bus_ready,
  output logic [31:0]      bus_rdata,
  input  logic [1:0]       acc_req,
  output logic [1:0]       acc_grant,
  output logic [1:0]       sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [SD_AW-1:0] sd_addr
);

  localparam int TMAX = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] MRD_LAST = CW'(T_MRD - 1);
  localparam logic [SD_AW-1:0] A10 = SD_AW'(1) << 10;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TRP, S_MRS, S_TMRD, S_DONE, S_RACK} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             area_q;
  logic [SD_AW-1:0] val_q;
  logic [1:0]       prog_q;

  logic [11:0]      off;
  logic             hit2, hit3, hit;
  logic [SD_AW-1:0] mrs_val;
  logic             cmd_on;

  assign off     = bus_addr[11:0];
  assign hit2    = bus_addr[31:12] == PAGE_A2;
  assign hit3    = bus_addr[31:12] == PAGE_A3;
  assign hit     = (hit2 | hit3) && (off <= 12'hFFC);
  assign mrs_val = bus_width32 ? SD_AW'(off >> 2) : SD_AW'(off >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      area_q <= 1'b0;
      val_q  <= '0;
      prog_q <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (bus_req && hit) begin
          area_q <= hit3;
          val_q  <= mrs_val;
          st     <= bus_we ? S_PRE : S_RACK;
        end
        S_PRE: begin
          cnt <= '0;
          st  <= S_TRP;
        end
        S_TRP: if (cnt == RP_LAST) st <= S_MRS;
               else cnt <= cnt + 1'b1;
        S_MRS: begin
          cnt <= '0;
          st  <= S_TMRD;
        end
        S_TMRD: if (cnt == MRD_LAST) st <= S_DONE;
                else cnt <= cnt + 1'b1;
        S_DONE: begin
          prog_q[area_q] <= 1'b1;
          st             <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_on    = (st == S_PRE) || (st == S_MRS);
  assign sd_cs_n   = cmd_on ? (area_q ? 2'b01 : 2'b10) : 2'b11;
  assign sd_ras_n  = !cmd_on;
  assign sd_we_n   = !cmd_on;
  assign sd_cas_n  = st != S_MRS;
  assign sd_addr   = (st == S_MRS) ? val_q : (st == S_PRE) ? A10 : '0;
  assign bus_ready = (st == S_DONE) || (st == S_RACK);
  assign bus_rdata = '0;
  assign acc_grant = acc_req & prog_q;

  logic unused_ok;
  assign unused_ok = ^bus_wdata;

  logic mrs_cmd;
  assign mrs_cmd = (sd_cs_n != 2'b11) && !sd_ras_n && !sd_cas_n && !sd_we_n;

  AST_MRS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_cmd |-> sd_addr == (bus_width32 ? SD_AW'(bus_addr[11:2]) : SD_AW'(bus_addr[11:1]))); // R3
  AST_MRS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_cmd |-> $past(sd_ras_n)); // R6
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prog_q) & prog_q) == $past(prog_q)); // R8
  AST_READ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ready) |-> sd_cs_n == 2'b11); // R9
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sd_cs_n)); // R1

endmodule

// File: tb/sdram_mrs_ctrl_tb.sv
module sdram_mrs_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int TRP = 2;
  localparam int TMRD = 2;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_width32 = 1;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_ready;
  logic [31:0] bus_rdata;
  logic [1:0] acc_req = 0, acc_grant, sd_cs_n;
  logic sd_ras_n, sd_cas_n, sd_we_n;
  logic [AW-1:0] sd_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mrs_ctrl #(.SD_AW(AW), .T_RP(TRP), .T_MRD(TMRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_width32(bus_width32),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .acc_req(acc_req),
    .acc_grant(acc_grant), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  int npre, nmrs, nrdy, maddr, pcs, mcs, gmrs;
  bit pre_ok, bad_cmd;

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input bit w32);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_width32 = w32;
    npre = -1; nmrs = -1; nrdy = -1; maddr = -1; pcs = -1; mcs = -1; gmrs = -1;
    pre_ok = 0; bad_cmd = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (sd_cs_n != 2'b11) begin
        if (!sd_ras_n && sd_cas_n && !sd_we_n) begin
          npre = n; pcs = sd_cs_n; pre_ok = sd_addr[10];
        end else if (!sd_ras_n && !sd_cas_n && !sd_we_n) begin
          nmrs = n; maddr = sd_addr; mcs = sd_cs_n; gmrs = acc_grant;
        end else bad_cmd = 1;
      end
      if (bus_ready) begin nrdy = n; break; end
    end
    bus_req = 0;
  endtask

  task automatic check_seq(input string req, input int exp_val, input int exp_cs);
    chk(npre == 1 && pcs == exp_cs && pre_ok && !bad_cmd, "R6", "precharge cycle", npre, 1);
    chk(nmrs == 2 + TRP, "R6", "mode-set cycle", nmrs, 2 + TRP);
    chk(nrdy == 3 + TRP + TMRD, "R7", "ready cycle", nrdy, 3 + TRP + TMRD);
    chk(mcs == exp_cs, "R1", "chip select", mcs, exp_cs);
    chk(maddr == exp_val, req, "mode value", maddr, exp_val);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    acc_req = 2'b11;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n, "R10", "pins in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'h1F);
    chk(bus_ready == 0, "R10", "ready in reset", bus_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(acc_grant == 2'b00, "R10", "grant after reset", acc_grant, 0);

    // R9 read hit
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 32'hFFFFD8C0;
    @(negedge clk);
    chk(bus_ready == 1 && bus_rdata == 0, "R9", "read ack", {bus_ready, bus_rdata[0]}, 2);
    chk(sd_cs_n == 2'b11, "R9", "no command on read", sd_cs_n, 3);
    bus_req = 0;
    @(negedge clk);
    chk(acc_grant == 2'b00, "R9", "read sets no flag", acc_grant, 0);

    // R2 outside range
    do_write(32'hFFFFDFFE, 0, 1);
    chk(npre == -1 && nmrs == -1 && nrdy == -1, "R2", "offset 0xFFE", nrdy, -1);
    do_write(32'hFFFFF8C0, 0, 1);
    chk(npre == -1 && nmrs == -1 && nrdy == -1, "R2", "foreign page", nrdy, -1);

    // R3 area 2, 32-bit
    do_write(32'hFFFFD8C0, 32'h12345678, 1);
    check_seq("R3", 32'h230, 2'b10);
    chk(gmrs == 2'b00, "R8", "grant during sequence", gmrs, 0);
    @(negedge clk);
    chk(acc_grant == 2'b01, "R8", "area2 granted only", acc_grant, 1);

    // R4 area 3, 16-bit
    do_write(32'hFFFFE8C2, 32'hCAFEF00D, 0);
    check_seq("R4", 32'h461, 2'b01);
    chk(gmrs == 2'b01, "R8", "area3 held during sequence", gmrs, 1);
    @(negedge clk);
    chk(acc_grant == 2'b11, "R8", "both granted", acc_grant, 3);

    // R5 data ignored
    do_write(32'hFFFFD8C0, 32'h00000000, 1);
    chk(maddr == 32'h230, "R5", "data zero", maddr, 32'h230);
    do_write(32'hFFFFD8C0, 32'hFFFFFFFF, 1);
    chk(maddr == 32'h230, "R5", "data ones", maddr, 32'h230);

    // sweep: both widths, both areas, all word offsets
    for (int w = 0; w < 2; w++)
      for (int ar = 0; ar < 2; ar++)
        for (int off = 0; off <= 32'hFFC; off += 4) begin
          logic [31:0] base;
          base = ar ? 32'hFFFFE000 : 32'hFFFFD000;
          do_write(base + off, ~(base + off), w[0]);
          check_seq(w ? "R3" : "R4", w ? (off >> 2) : (off >> 1), ar ? 2'b01 : 2'b10);
        end

    // R10 reset again clears flags
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(acc_grant == 2'b00, "R10", "flags cleared", acc_grant, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule